// File: doc/BRIEF.md
# Triple-Voted I2C Configuration Bank

This block is an I2C target that holds a bank of byte-wide configuration registers. Each stored bit exists in three copies. A bitwise majority vote resolves the copies, and the result drives the configuration bus to downstream logic. The target responds to one fixed 7-bit device address.

A host writes one byte with a frame of the form: device byte with the write bit, register index, data. To read, the host first sends the register index in a write-direction frame without data. It then issues a repeated START and the device byte with the read bit, and the target returns the voted byte. A read never changes the configuration bus, so the bank can be read while the rest of the chip is running. Every access rewrites all three copies of the whole bank from the voted value, which clears any single-copy upset.

A second access path is available for older boards. It is a plain serial chain through the whole bank, clocked by a shift strobe from the system clock domain. A fault-injection port can flip chosen copies of one bit, so that the voting and the scrubbing can be observed at the pins.

Top module: `tmr_i2c_cfg_bank`

## Requirements
- R1: After reset every configuration bit is 0, the target does not pull SDA low (`sda_oe` = 0), and `sr_dout` is 0.
- R2: For a write frame whose device byte is {DEV_ADDR, 0}, the target pulls SDA low in the acknowledge slot after each of the three bytes. It changes `sda_oe` only while SCL is low. Register k, for k below NUM_REGS, then appears on `cfg_out[8k+7:8k]`.
- R3: For a read sequence (index frame, repeated START, device byte {DEV_ADDR, 1}), the target acknowledges the device byte and the index byte, then returns the voted byte of register k MSB first. `cfg_out` is unchanged by the read.
- R4: For a device byte whose upper seven bits differ from DEV_ADDR, the target gives no acknowledge for any slot of that frame, and the bank is unchanged.
- R5: For register indices at or above NUM_REGS, a write is acknowledged but changes nothing, and a read returns 0x00.
- R6: `seu_copy` is a three-bit mask with bit c selecting copy c. `seu_bit` is an index into the flat `cfg_out` vector. One-copy upsets selected this way leave `cfg_out` unchanged. A second upset of the same bit in another copy inverts that bit of `cfg_out`.
- R7: Any I2C read, I2C write or chain shift rewrites all three copies of every bit with the voted value, with the new data merged in. After a scrubbing access, one further single-copy upset leaves `cfg_out` unchanged.
- R8: While `sr_mode` = 1, each cycle with `sr_shift` = 1 moves `cfg_out` up one position and puts `sr_din` into bit 0. `sr_dout` always shows the top bit of `cfg_out`. With `sr_shift` = 0, or with `sr_mode` = 0, the bank holds its value.
- R9: While `sr_mode` = 1, the I2C engine is held idle: no acknowledge is given and no I2C write reaches the bank.
- R10: After the last bit of a returned byte, the target releases SDA before the host's NACK slot and keeps it released through STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 pulls the SDA pad low |
| sr_mode | input | 1 | Selects the serial chain path and idles I2C |
| sr_shift | input | 1 | One-cycle strobe advancing the chain |
| sr_din | input | 1 | Serial data entering bit 0 |
| sr_dout | output | 1 | Top bit of the voted chain |
| seu_copy | input | 3 | Fault mask, one bit per copy |
| seu_bit | input | log2(8*NUM_REGS) | Bit index for the fault mask |
| cfg_out | output | 8*NUM_REGS | Voted configuration bits, register k at bits 8k+7..8k |

## Verification
The bench builds the block with NUM_REGS = 4 and DEV_ADDR = 0x71 (device write byte 0xE2). With only four registers, a byte index such as 0x73 falls outside the bank, which brings out the ignored-write and zero-read cases, and the 32-bit chain can be shifted through in full. The bench runs the bus with an SCL period of 32 system clocks, long enough for the two-stage synchronizer and the edge registers to settle before each sample point. Single and double upsets placed before and after scrubbing accesses make the vote and the rewrite visible on `cfg_out`.

// File: rtl/tmr_cfg_pkg.sv
`timescale 1ns/1ps
package tmr_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_REG,
    ST_ACK_REG, ST_DATA, ST_ACK_DATA, ST_TX
  } tgt_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/i2c_edge_det.sv
`timescale 1ns/1ps
module i2c_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, sda_m, scl_p, sda_p;

  // two-stage synchronizers, then one history stage for edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
`timescale 1ns/1ps
module i2c_target_fsm
  import tmr_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h71
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_s,
  input  logic [7:0] rd_data,
  output logic [7:0] reg_ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  tgt_state_e st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d, ptr_q, ptr_d;
  logic       rw_q, rw_d, oe_q, oe_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; ptr_d = ptr_q;
    rw_d = rw_q; oe_d = oe_q;
    wr_en = 1'b0; wr_data = sh_q;
    if (hold || stop_det) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (start_det) begin
      st_d = ST_ADDR; cnt_d = 4'd0; oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_REG, ST_DATA: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = 4'd0;
            if (st_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                rw_d = sh_q[0]; oe_d = 1'b1; st_d = ST_ACK_ADDR;
              end else begin
                st_d = ST_IDLE;
              end
            end else if (st_q == ST_REG) begin
              ptr_d = sh_q; oe_d = 1'b1; st_d = ST_ACK_REG;
            end else begin
              wr_en = 1'b1; oe_d = 1'b1; st_d = ST_ACK_DATA;
            end
          end
        end
        ST_ACK_ADDR: if (scl_fall) begin
          if (rw_q) begin
            sh_d = rd_data; oe_d = ~rd_data[7];
            wr_en = 1'b1; wr_data = rd_data;   // scrub on read
            cnt_d = 4'd0; st_d = ST_TX;
          end else begin
            oe_d = 1'b0; st_d = ST_REG;
          end
        end
        ST_ACK_REG:  if (scl_fall) begin oe_d = 1'b0; st_d = ST_DATA; end
        ST_ACK_DATA: if (scl_fall) begin oe_d = 1'b0; st_d = ST_IDLE; end
        ST_TX: if (scl_fall) begin
          if (cnt_q == 4'd7) begin
            oe_d = 1'b0; st_d = ST_IDLE;
          end else begin
            sh_d = {sh_q[6:0], 1'b0}; oe_d = ~sh_q[6]; cnt_d = cnt_q + 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= 4'd0; sh_q <= 8'd0;
      ptr_q <= 8'd0; rw_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d;
      ptr_q <= ptr_d; rw_q <= rw_d; oe_q <= oe_d;
    end
  end

  assign reg_ptr = ptr_q;
  assign sda_oe  = oe_q;
endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank #(
  parameter  int NUM_REGS = 4,
  localparam int NB = NUM_REGS * 8,
  localparam int IW = $clog2(NUM_REGS * 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  logic [7:0]    acc_addr,
  input  logic [7:0]    acc_data,
  input  logic          sh_en,
  input  logic          sh_din,
  input  logic [2:0]    seu_copy,
  input  logic [IW-1:0] seu_bit,
  output logic [NB-1:0] voted,
  output logic [7:0]    rd_data
);
  localparam int AW = $clog2(NUM_REGS);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  logic [NB-1:0] cp_q [3];
  logic [NB-1:0] cp_d [3];
  logic [NB-1:0] base;
  logic          hit;
  logic [AW+2:0] boff;

  for (genvar i = 0; i < NB; i++) begin : g_vote
    assign voted[i] = tmr_cfg_pkg::maj3(cp_q[0][i], cp_q[1][i], cp_q[2][i]);
  end

  assign hit     = acc_addr < NREG8;
  assign boff    = {acc_addr[AW-1:0], 3'b000};
  assign rd_data = hit ? voted[boff +: 8] : 8'h00;

  always_comb begin
    base = voted;
    if (sh_en)              base = {voted[NB-2:0], sh_din};
    else if (acc_wr && hit) base[boff +: 8] = acc_data;
    for (int c = 0; c < 3; c++) begin
      cp_d[c] = (sh_en || acc_wr) ? base : cp_q[c];
      if (seu_copy[c]) cp_d[c][seu_bit] = ~cp_d[c][seu_bit];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) cp_q[c] <= '0;
    end else begin
      for (int c = 0; c < 3; c++) cp_q[c] <= cp_d[c];
    end
  end
endmodule

// File: rtl/tmr_i2c_cfg_bank.sv
`timescale 1ns/1ps
module tmr_i2c_cfg_bank #(
  parameter logic [6:0] DEV_ADDR = 7'h71,
  parameter int         NUM_REGS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              scl_i,
  input  logic                              sda_i,
  output logic                              sda_oe,
  input  logic                              sr_mode,
  input  logic                              sr_shift,
  input  logic                              sr_din,
  output logic                              sr_dout,
  input  logic [2:0]                        seu_copy,
  input  logic [$clog2(NUM_REGS*8)-1:0]     seu_bit,
  output logic [NUM_REGS*8-1:0]             cfg_out
);
  localparam int NB = NUM_REGS * 8;

  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       bank_wr;
  logic [7:0] bank_addr, bank_wdata, bank_rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  i2c_edge_det u_edge (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .hold(sr_mode),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .rd_data(bank_rdata), .reg_ptr(bank_addr),
    .wr_en(bank_wr), .wr_data(bank_wdata), .sda_oe(sda_oe)
  );

  tmr_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_sn),
    .acc_wr(bank_wr), .acc_addr(bank_addr), .acc_data(bank_wdata),
    .sh_en(sr_mode & sr_shift), .sh_din(sr_din),
    .seu_copy(seu_copy), .seu_bit(seu_bit),
    .voted(cfg_out), .rd_data(bank_rdata)
  );

  assign sr_dout = cfg_out[NB-1];
endmodule

// File: rtl/tmr_i2c_cfg_chk.sv
`timescale 1ns/1ps
module tmr_i2c_cfg_chk #(
  parameter int NB = 32
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          sr_mode,
  input logic          sr_shift,
  input logic          sr_din,
  input logic [2:0]    seu_copy,
  input logic [NB-1:0] cfg_out,
  input logic          sda_oe,
  input logic          bank_wr,
  input logic          stop_det,
  input logic          scl_s
);
  p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(sda_oe) |-> !scl_s);

  p_shift_move_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (sr_mode && sr_shift && seu_copy == 3'b000)
      |=> cfg_out == {$past(cfg_out[NB-2:0]), $past(sr_din)});

  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (!bank_wr && !(sr_mode && sr_shift) && seu_copy == 3'b000) |=> $stable(cfg_out));

  p_sr_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (sr_mode && $past(sr_mode)) |-> !sda_oe);

  p_sr_no_write_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    sr_mode |-> !bank_wr);

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(stop_det) |-> !sda_oe);
endmodule

bind tmr_i2c_cfg_bank tmr_i2c_cfg_chk #(.NB(NUM_REGS * 8)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .sr_mode(sr_mode), .sr_shift(sr_shift),
  .sr_din(sr_din), .seu_copy(seu_copy), .cfg_out(cfg_out), .sda_oe(sda_oe),
  .bank_wr(bank_wr), .stop_det(stop_det), .scl_s(scl_s)
);

// File: tb/sim_tmr_i2c_cfg_bank.sv
`timescale 1ns/1ps
module sim_tmr_i2c_cfg_bank;
  localparam int NREG = 4;
  localparam int NB = NREG * 8;
  localparam logic [6:0] DEV = 7'h71;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sr_mode = 1'b0, sr_shift = 1'b0, sr_din = 1'b0;
  logic [2:0] seu_copy = 3'b000;
  logic [$clog2(NB)-1:0] seu_bit = '0;
  logic sda_oe, sr_dout, sda_bus;
  logic [NB-1:0] cfg_out;
  logic [NB-1:0] mv;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  tmr_i2c_cfg_bank #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .sr_mode(sr_mode), .sr_shift(sr_shift), .sr_din(sr_din), .sr_dout(sr_dout),
    .seu_copy(seu_copy), .seu_bit(seu_bit), .cfg_out(cfg_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] r);
    return (r < NREG) ? mv[r*8 +: 8] : 8'h00;
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic v);
    sda_m = v; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic v);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    v = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic wr_frame(input logic [6:0] dev, input logic [7:0] r, input logic [7:0] d,
                          output logic [2:0] acks);
    bus_start;
    send_byte({dev, 1'b0}, acks[2]);
    send_byte(r, acks[1]);
    send_byte(d, acks[0]);
    bus_stop;
    tick(4);
  endtask

  task automatic rd_frame(input logic [6:0] dev, input logic [7:0] r, output logic [7:0] d,
                          output logic [2:0] acks, output logic oe_nack);
    logic b;
    bus_start;
    send_byte({dev, 1'b0}, acks[2]);
    send_byte(r, acks[1]);
    bus_start;
    send_byte({dev, 1'b1}, acks[0]);
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    oe_nack = sda_oe; tick(Q); scl_m = 1'b0; tick(Q);
    bus_stop;
    tick(4);
  endtask

  task automatic upset(input logic [2:0] m, input int k);
    seu_copy = m; seu_bit = k[$clog2(NB)-1:0]; tick(1);
    seu_copy = 3'b000; tick(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] rd, r, d;
    logic onack;
    void'($urandom(32'd4711));
    mv = '0;
    tick(5); rst_n = 1'b1; tick(6);

    // R1 reset state
    check("R1 cfg_out", cfg_out, '0);
    check("R1 sda_oe", sda_oe, 1'b0);
    check("R1 sr_dout", sr_dout, 1'b0);

    // R5 out-of-range index with the example bytes (write byte 0xE2, index 0x73, data 0x83)
    wr_frame(DEV, 8'h73, 8'h83, acks);
    check("R5 acks on out-of-range write", acks, 3'b111);
    check("R5 bank unchanged", cfg_out, mv);
    rd_frame(DEV, 8'h73, rd, acks, onack);
    check("R5 out-of-range read", rd, 8'h00);

    // R2 directed write
    wr_frame(DEV, 8'h02, 8'h83, acks);
    mv[16 +: 8] = 8'h83;
    check("R2 acks", acks, 3'b111);
    check("R2 cfg_out", cfg_out, mv);

    // R2/R3 random writes and reads
    for (int i = 0; i < 12; i++) begin
      r = 8'($urandom % NREG); d = 8'($urandom);
      wr_frame(DEV, r, d, acks);
      mv[r*8 +: 8] = d;
      check("R2 random acks", acks, 3'b111);
      check("R2 random cfg_out", cfg_out, mv);
      r = 8'($urandom % NREG);
      rd_frame(DEV, r, rd, acks, onack);
      check("R3 read acks", acks, 3'b111);
      check("R3 read data", rd, exp_read(r));
      check("R3 cfg unchanged by read", cfg_out, mv);
      check("R10 released at NACK", onack, 1'b0);
      check("R10 released after stop", sda_oe, 1'b0);
    end

    // R4 mismatched device address
    wr_frame(DEV ^ 7'h01, 8'h01, 8'h5A, acks);
    check("R4 no acks", acks, 3'b000);
    check("R4 bank unchanged", cfg_out, mv);
    rd_frame(7'h22, 8'h00, rd, acks, onack);
    check("R4 no acks on read", acks, 3'b000);

    // R6 voting
    upset(3'b001, 5);
    check("R6 single upset hidden", cfg_out, mv);
    upset(3'b100, 5);
    mv[5] = ~mv[5];
    check("R6 double upset visible", cfg_out, mv);
    upset(3'b011, 20);
    mv[20] = ~mv[20];
    check("R6 two copies at once", cfg_out, mv);

    // R7 scrub by read
    upset(3'b001, 9);
    rd_frame(DEV, 8'h03, rd, acks, onack);
    check("R7 read data", rd, exp_read(8'h03));
    upset(3'b010, 9);
    check("R7 scrub by read", cfg_out, mv);
    // R7 scrub by write
    upset(3'b100, 30);
    wr_frame(DEV, 8'h00, 8'hC3, acks);
    mv[7:0] = 8'hC3;
    upset(3'b001, 30);
    check("R7 scrub by write", cfg_out, mv);

    // R8 chain path
    sr_mode = 1'b1; tick(2);
    for (int i = 0; i < 40; i++) begin
      sr_din = 1'($urandom); sr_shift = 1'b1; tick(1);
      sr_shift = 1'b0;
      mv = {mv[NB-2:0], sr_din};
      check("R8 shift cfg_out", cfg_out, mv);
      check("R8 sr_dout", sr_dout, mv[NB-1]);
    end
    tick(5);
    check("R8 hold without strobe", cfg_out, mv);

    // R9 I2C ignored in chain mode
    wr_frame(DEV, 8'h01, ~mv[15:8], acks);
    check("R9 no acks", acks, 3'b000);
    check("R9 bank unchanged", cfg_out, mv);
    sr_mode = 1'b0; tick(2);
    sr_din = 1'b1; sr_shift = 1'b1; tick(3); sr_shift = 1'b0; tick(1);
    check("R8 strobe ignored with sr_mode low", cfg_out, mv);
    rd_frame(DEV, 8'h01, rd, acks, onack);
    check("R3 read after chain load", rd, exp_read(8'h01));

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule